// File: doc/BRIEF.md
# Serial Bit-Addressed Peripheral Decoder

This block sits on a single-bit I/O bus: the processor presents an address, one output data bit and a write strobe, and it samples one input data bit. The block turns that bus into the peripheral state of a small home computer. The state covers the keyboard row drives, a video display enable, a four-line parallel peripheral port with handshake, bus-available and inhibit lines, and a tape interface bit. Reads return keyboard column inputs or peripheral port inputs.

A 2 KiB keyboard window holds eight bit slots that repeat across the whole window. Slots 0 to 5 drive the keyboard rows, slot 6 accepts writes but discards them, and slot 7 holds the video enable. A separate 16-byte peripheral window holds eight slots in a fixed order: data lines 0 to 3, handshake, bus-available, inhibit and tape. Inhibit can only be written. The latched keyboard row 0 also serves as the bank select for a banked ROM window. Because of this, scanning keyboard row 0 changes the bank.

Top module: `io_bit_ctrl`

## Requirements
- R1: After reset, all latched outputs are 0: kbd_rows, video_en, rom_bank, hex_data_out, hex_hsk_out, hex_bav_out, hex_inhibit and tape_out.
- R2: When io_wstrobe is high at a rising clock edge and the address is in the keyboard window with address bits [3:1] = k (k from 0 to 5), kbd_rows[k] takes io_wdata at that edge.
- R3: A strobed write in the keyboard window with bits [3:1] = 6 changes no output.
- R4: A strobed write in the keyboard window with bits [3:1] = 7 sets video_en to io_wdata.
- R5: A read in the keyboard window returns kbd_cols[bits 3:1] combinationally on io_rdata.
- R6: The keyboard window is every address from 0xE000 to 0xE7FF. Bits [10:4] are ignored there for both reads and writes.
- R7: A strobed write at 0xE800 to 0xE80E, with bits [3:1] = s, sets the following from io_wdata: hex_data_out[s] for s = 0 to 3, hex_hsk_out for s = 4, hex_bav_out for s = 5, hex_inhibit for s = 6, and tape_out for s = 7.
- R8: A read at 0xE800 to 0xE80E returns the following: hex_data_in[s] for s = 0 to 3, hex_hsk_in for s = 4, hex_bav_in for s = 5, and tape_in for s = 7. Slot 6 (inhibit, 0xE80C) reads 1.
- R9: A read at any address outside both windows returns 1. A strobed write there changes no output.
- R10: rom_bank always equals the keyboard row 0 latch.
- R11: No latched output changes at a clock edge where io_wstrobe is low.
- R12: Address bit 0 is ignored, so an odd address acts like the even address below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Bit address of the I/O bus |
| io_wdata | input | 1 | Output data bit for writes |
| io_wstrobe | input | 1 | Write strobe, sampled at the rising edge |
| io_rdata | output | 1 | Input data bit for the addressed slot |
| kbd_cols | input | 8 | Keyboard column inputs |
| kbd_rows | output | 6 | Latched keyboard row drives |
| video_en | output | 1 | Video enable latch |
| rom_bank | output | 1 | ROM bank select (row 0 latch) |
| hex_data_in | input | 4 | Peripheral port data inputs |
| hex_data_out | output | 4 | Peripheral port data latches |
| hex_hsk_in | input | 1 | Handshake input |
| hex_hsk_out | output | 1 | Handshake latch |
| hex_bav_in | input | 1 | Bus-available input |
| hex_bav_out | output | 1 | Bus-available latch |
| hex_inhibit | output | 1 | Inhibit latch (write only) |
| tape_in | input | 1 | Tape input bit |
| tape_out | output | 1 | Tape output latch |

## Verification
A read has no latency: io_rdata settles in the same cycle as the address and the inputs. The bench therefore sets them away from the clock edge and samples io_rdata a short delay later, before any edge. A strobed write lands at the next rising edge. The bench drives it on a falling edge, drops the strobe at the following falling edge and compares every latched output then, one edge after the stimulus. Cycles with no strobe are checked the same way to show that nothing moved.

// File: rtl/io_ctl_pkg.sv
package io_ctl_pkg;
   localparam int SLOT_W = 3;
   localparam int SLOTS  = 2 ** SLOT_W;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_KBD  = 2'd1,
      RGN_HEX  = 2'd2
   } region_e;

   typedef struct packed {
      region_e             rgn;
      logic [SLOT_W-1:0]   slot;
   } decode_t;
endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
   import io_ctl_pkg::*;
#(
   parameter int                ADDR_W        = 16,
   parameter int                KBD_SPAN_LOG2 = 11,
   parameter logic [ADDR_W-1:0] KBD_BASE      = 16'hE000,
   parameter logic [ADDR_W-1:0] HEX_BASE      = 16'hE800
) (
   input  logic [ADDR_W-1:0] addr,
   output decode_t           dec
);
   localparam int HEX_LO = SLOT_W + 1;

   if (KBD_SPAN_LOG2 <= SLOT_W || KBD_SPAN_LOG2 >= ADDR_W) begin : g_bad_span
      $error("KBD_SPAN_LOG2 out of range");
   end

   logic kbd_hit;
   logic hex_hit;

   assign kbd_hit = addr[ADDR_W-1:KBD_SPAN_LOG2] == KBD_BASE[ADDR_W-1:KBD_SPAN_LOG2];
   assign hex_hit = addr[ADDR_W-1:HEX_LO] == HEX_BASE[ADDR_W-1:HEX_LO];

   always_comb begin
      dec.slot = addr[SLOT_W:1];
      if (kbd_hit)      dec.rgn = RGN_KBD;
      else if (hex_hit) dec.rgn = RGN_HEX;
      else              dec.rgn = RGN_NONE;
   end
endmodule

// File: rtl/io_latch_bank.sv
module io_latch_bank
   import io_ctl_pkg::*;
#(
   parameter int ROWS       = 6,
   parameter int HEX_DATA_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wstrobe,
   input  logic                  wdata,
   input  decode_t               dec,
   output logic [ROWS-1:0]       rows,
   output logic                  video_en,
   output logic [HEX_DATA_W-1:0] hex_dout,
   output logic                  hsk_o,
   output logic                  bav_o,
   output logic                  inh_o,
   output logic                  tape_o
);
   localparam int VID_SLOT  = SLOTS - 1;
   localparam int HSK_SLOT  = HEX_DATA_W;
   localparam int BAV_SLOT  = HEX_DATA_W + 1;
   localparam int INH_SLOT  = HEX_DATA_W + 2;
   localparam int TAPE_SLOT = HEX_DATA_W + 3;

   if (ROWS < 1 || ROWS > SLOTS - 1) begin : g_bad_rows
      $error("ROWS must leave the last slot for video enable");
   end
   if (HEX_DATA_W < 1 || HEX_DATA_W + 4 > SLOTS) begin : g_bad_hex
      $error("HEX_DATA_W does not fit the peripheral window");
   end

   logic wr_kbd;
   logic wr_hex;

   assign wr_kbd = wstrobe && (dec.rgn == RGN_KBD);
   assign wr_hex = wstrobe && (dec.rgn == RGN_HEX);

   for (genvar i = 0; i < ROWS; i++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                         rows[i] <= 1'b0;
         else if (wr_kbd && dec.slot == SLOT_W'(i))          rows[i] <= wdata;
      end

      assert_row_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (wstrobe && dec.rgn == RGN_KBD && dec.slot == SLOT_W'(i)) |=> (rows[i] == $past(wdata)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            video_en <= 1'b0;
      else if (wr_kbd && dec.slot == SLOT_W'(VID_SLOT))      video_en <= wdata;
   end

   for (genvar j = 0; j < HEX_DATA_W; j++) begin : g_hex
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                         hex_dout[j] <= 1'b0;
         else if (wr_hex && dec.slot == SLOT_W'(j))          hex_dout[j] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsk_o  <= 1'b0;
         bav_o  <= 1'b0;
         inh_o  <= 1'b0;
         tape_o <= 1'b0;
      end else if (wr_hex) begin
         if (dec.slot == SLOT_W'(HSK_SLOT))  hsk_o  <= wdata;
         if (dec.slot == SLOT_W'(BAV_SLOT))  bav_o  <= wdata;
         if (dec.slot == SLOT_W'(INH_SLOT))  inh_o  <= wdata;
         if (dec.slot == SLOT_W'(TAPE_SLOT)) tape_o <= wdata;
      end
   end

   logic [ROWS+HEX_DATA_W+4:0] all_q;
   assign all_q = {rows, video_en, hex_dout, hsk_o, bav_o, inh_o, tape_o};

   assert_hold_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !wstrobe |=> $stable(all_q));

   assert_video_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wstrobe && dec.rgn == RGN_KBD && dec.slot == SLOT_W'(VID_SLOT)) |=> (video_en == $past(wdata)));

   assert_spare_slot_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wstrobe && dec.rgn == RGN_KBD && dec.slot >= SLOT_W'(ROWS) && dec.slot != SLOT_W'(VID_SLOT))
      |=> $stable(all_q));

   assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.rgn == RGN_NONE) |=> $stable(all_q));

   assert_inhibit_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wstrobe && dec.rgn == RGN_HEX && dec.slot == SLOT_W'(INH_SLOT)) |=> (inh_o == $past(wdata)));
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
   import io_ctl_pkg::*;
#(
   parameter int HEX_DATA_W = 4
) (
   input  decode_t               dec,
   input  logic [SLOTS-1:0]      kbd_cols,
   input  logic [HEX_DATA_W-1:0] hex_din,
   input  logic                  hsk_i,
   input  logic                  bav_i,
   input  logic                  tape_i,
   output logic                  rdata
);
   localparam int HSK_SLOT  = HEX_DATA_W;
   localparam int BAV_SLOT  = HEX_DATA_W + 1;
   localparam int TAPE_SLOT = HEX_DATA_W + 3;

   logic hex_bit;

   always_comb begin
      hex_bit = 1'b1;
      if (int'(dec.slot) < HEX_DATA_W)              hex_bit = hex_din[dec.slot];
      else if (dec.slot == SLOT_W'(HSK_SLOT))       hex_bit = hsk_i;
      else if (dec.slot == SLOT_W'(BAV_SLOT))       hex_bit = bav_i;
      else if (dec.slot == SLOT_W'(TAPE_SLOT))      hex_bit = tape_i;
   end

   always_comb begin
      unique case (dec.rgn)
         RGN_KBD: rdata = kbd_cols[dec.slot];
         RGN_HEX: rdata = hex_bit;
         default: rdata = 1'b1;
      endcase
   end
endmodule

// File: rtl/io_bit_ctrl.sv
module io_bit_ctrl
   import io_ctl_pkg::*;
#(
   parameter int ADDR_W        = 16,
   parameter int KBD_SPAN_LOG2 = 11,
   parameter int ROWS          = 6,
   parameter int HEX_DATA_W    = 4,
   parameter logic [ADDR_W-1:0] KBD_BASE = 16'hE000,
   parameter logic [ADDR_W-1:0] HEX_BASE = 16'hE800
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic                  io_wdata,
   input  logic                  io_wstrobe,
   output logic                  io_rdata,
   input  logic [SLOTS-1:0]      kbd_cols,
   output logic [ROWS-1:0]       kbd_rows,
   output logic                  video_en,
   output logic                  rom_bank,
   input  logic [HEX_DATA_W-1:0] hex_data_in,
   output logic [HEX_DATA_W-1:0] hex_data_out,
   input  logic                  hex_hsk_in,
   output logic                  hex_hsk_out,
   input  logic                  hex_bav_in,
   output logic                  hex_bav_out,
   output logic                  hex_inhibit,
   input  logic                  tape_in,
   output logic                  tape_out
);
   localparam int INH_SLOT = HEX_DATA_W + 2;

   decode_t dec;

   io_addr_decode #(
      .ADDR_W(ADDR_W), .KBD_SPAN_LOG2(KBD_SPAN_LOG2),
      .KBD_BASE(KBD_BASE), .HEX_BASE(HEX_BASE)
   ) u_decode (
      .addr(io_addr),
      .dec (dec)
   );

   io_latch_bank #(.ROWS(ROWS), .HEX_DATA_W(HEX_DATA_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wstrobe (io_wstrobe),
      .wdata   (io_wdata),
      .dec     (dec),
      .rows    (kbd_rows),
      .video_en(video_en),
      .hex_dout(hex_data_out),
      .hsk_o   (hex_hsk_out),
      .bav_o   (hex_bav_out),
      .inh_o   (hex_inhibit),
      .tape_o  (tape_out)
   );

   io_read_mux #(.HEX_DATA_W(HEX_DATA_W)) u_rmux (
      .dec     (dec),
      .kbd_cols(kbd_cols),
      .hex_din (hex_data_in),
      .hsk_i   (hex_hsk_in),
      .bav_i   (hex_bav_in),
      .tape_i  (tape_in),
      .rdata   (io_rdata)
   );

   assign rom_bank = kbd_rows[0];

   assert_bank_moves_on_row0_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rom_bank) |-> $past(io_wstrobe && dec.rgn == RGN_KBD && dec.slot == '0));

   assert_unmapped_reads_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.rgn == RGN_NONE) |-> io_rdata);

   assert_inhibit_reads_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec.rgn == RGN_HEX && dec.slot == SLOT_W'(INH_SLOT)) |-> io_rdata);
endmodule

// File: tb/test_io_bit_ctrl.sv
`timescale 1ns/1ps
module test_io_bit_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wdata = 1'b0;
   logic        io_wstrobe = 1'b0;
   logic        io_rdata;
   logic [7:0]  kbd_cols = '0;
   logic [5:0]  kbd_rows;
   logic        video_en, rom_bank;
   logic [3:0]  hex_data_in = '0;
   logic [3:0]  hex_data_out;
   logic        hex_hsk_in = 1'b0, hex_hsk_out;
   logic        hex_bav_in = 1'b0, hex_bav_out;
   logic        hex_inhibit;
   logic        tape_in = 1'b0, tape_out;

   always #5 clk = ~clk;

   io_bit_ctrl i_io_bit_ctrl (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wstrobe(io_wstrobe), .io_rdata(io_rdata), .kbd_cols(kbd_cols),
      .kbd_rows(kbd_rows), .video_en(video_en), .rom_bank(rom_bank),
      .hex_data_in(hex_data_in), .hex_data_out(hex_data_out),
      .hex_hsk_in(hex_hsk_in), .hex_hsk_out(hex_hsk_out),
      .hex_bav_in(hex_bav_in), .hex_bav_out(hex_bav_out),
      .hex_inhibit(hex_inhibit), .tape_in(tape_in), .tape_out(tape_out));

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [5:0] m_rows;
   logic       m_vid, m_hsk, m_bav, m_inh, m_tape;
   logic [3:0] m_hd;

   function automatic logic exp_read(logic [15:0] a);
      logic [2:0] s = a[3:1];
      if (a[15:11] == 5'b11100) return kbd_cols[s];
      if (a[15:4] == 12'hE80) begin
         case (s)
            3'd4:    return hex_hsk_in;
            3'd5:    return hex_bav_in;
            3'd6:    return 1'b1;
            3'd7:    return tape_in;
            default: return hex_data_in[s];
         endcase
      end
      return 1'b1;
   endfunction

   task automatic model_write(logic [15:0] a, logic d);
      logic [2:0] s = a[3:1];
      if (a[15:11] == 5'b11100) begin
         if (s < 3'd6) m_rows[s] = d;
         else if (s == 3'd7) m_vid = d;
      end else if (a[15:4] == 12'hE80) begin
         case (s)
            3'd4:    m_hsk = d;
            3'd5:    m_bav = d;
            3'd6:    m_inh = d;
            3'd7:    m_tape = d;
            default: m_hd[s] = d;
         endcase
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("[TB] FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_state(string req);
      check(req, {16'd0, kbd_rows, video_en, rom_bank, hex_data_out, hex_hsk_out,
                  hex_bav_out, hex_inhibit, tape_out},
                 {16'd0, m_rows, m_vid, m_rows[0], m_hd, m_hsk, m_bav, m_inh, m_tape});
   endtask

   task automatic do_write(logic [15:0] a, logic d, string req);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wstrobe = 1'b1;
      @(negedge clk);
      io_wstrobe = 1'b0;
      model_write(a, d);
      check_state(req);
   endtask

   task automatic do_read(logic [15:0] a, string req);
      @(negedge clk);
      io_addr = a;
      kbd_cols = 8'($urandom); hex_data_in = 4'($urandom);
      hex_hsk_in = 1'($urandom); hex_bav_in = 1'($urandom); tape_in = 1'($urandom);
      #1;
      check(req, {31'd0, io_rdata}, {31'd0, exp_read(a)});
   endtask

   function automatic logic [15:0] rand_addr();
      case ($urandom % 4)
         0: return 16'hE000 | 16'($urandom & 32'h7FF);
         1: return 16'hE800 | 16'($urandom & 32'hF);
         2: return 16'($urandom);
         default: return 16'hE000 | 16'($urandom & 32'hF);
      endcase
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      m_rows = '0; m_vid = 0; m_hsk = 0; m_bav = 0; m_inh = 0; m_tape = 0; m_hd = '0;
      repeat (3) @(negedge clk);
      check_state("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after release");

      for (int k = 0; k < 6; k++) do_write(16'hE000 + 16'(2 * k), 1'b1, "R2 row set");
      do_write(16'hE000, 1'b0, "R2 row0 clear / R10 bank");
      do_write(16'hE000, 1'b1, "R10 bank follows row0");
      do_write(16'hE00C, 1'b1, "R3 spare slot ignored");
      do_write(16'hE00C, 1'b0, "R3 spare slot ignored");
      do_write(16'hE00E, 1'b1, "R4 video enable set");
      do_write(16'hE7F4, 1'b0, "R6 mirror write row2");
      do_write(16'hE3FF, 1'b0, "R6 R4 mirror odd video");
      do_write(16'hE005, 1'b0, "R12 odd address row2");
      for (int s = 0; s < 8; s++) do_write(16'hE800 + 16'(2 * s), 1'b1, "R7 peripheral write");
      do_write(16'hE80C, 1'b0, "R7 inhibit clear");
      do_write(16'hF000, 1'b0, "R9 unmapped write");
      do_write(16'hE810, 1'b0, "R9 past peripheral window");
      do_write(16'hDFFE, 1'b0, "R9 below keyboard window");

      @(negedge clk);
      io_addr = 16'hE002; io_wdata = 1'b0; io_wstrobe = 1'b0;
      @(negedge clk);
      check_state("R11 no strobe no change");

      for (int s = 0; s < 8; s++) do_read(16'hE000 + 16'(2 * s), "R5 column read");
      do_read(16'hE5A6, "R6 mirror read");
      do_read(16'hE00B, "R12 odd read");
      for (int s = 0; s < 8; s++) do_read(16'hE800 + 16'(2 * s), "R8 peripheral read");
      do_read(16'hE80C, "R8 inhibit reads one");
      do_read(16'h0000, "R9 unmapped read");
      do_read(16'hFFFE, "R9 unmapped read");

      for (int i = 0; i < 600; i++) begin
         logic [15:0] a = rand_addr();
         case ($urandom % 3)
            0: do_write(a, 1'($urandom), "R2 R4 R7 R9 random write");
            1: do_read(a, "R5 R8 R9 random read");
            default: begin
               @(negedge clk);
               io_addr = a; io_wdata = 1'($urandom); io_wstrobe = 1'b0;
               @(negedge clk);
               check_state("R11 random idle");
            end
         endcase
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("[TB] FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule